// File: doc/BRIEF.md
# JTAG Identification Code Reader

This block is a JTAG host engine. It drives the test clock, mode select and data-in lines of one attached target and listens to its data-out line. Each start pulse runs one fixed transaction. The transaction resets the target's test access port and parks it in Run-Test-Idle. It then loads the 8-bit read-identification opcode 0x11 into the instruction register. Next it walks the data-register path and shifts out a 32-bit identification word. The target ends in Run-Test-Idle. When the transaction finishes, the block presents the captured word, a one-cycle done strobe, and a flag. The flag is set when the low 12 bits, the manufacturer field, equal a configured value. The default for that value is 0x81B. Bits 31..12 carry the device part code and are passed through unchecked.

The test clock is the system clock divided by 2*TCK_HALF, with equal high and low phases. The block changes TMS and TDI in the system cycle where TCK falls. It samples TDO in the system cycle where TCK rises.

A sequencer steps through these states, one TCK period per step and one transition per TCK falling edge:
- IDLE goes to TAP_RESET on start.
- TAP_RESET lasts five periods with TMS=1.
- ENTER_RTI (TMS 0), SEL_DR_A (1), SEL_IR (1), CAP_IR (0) and ENTER_SIR (0) follow, one period each.
- SHIFT_IR lasts eight periods.
- UPD_IR (1), SEL_DR_B (1), CAP_DR (0) and ENTER_SDR (0) follow, one period each.
- SHIFT_DR lasts 32 periods.
- UPD_DR (1) and BACK_RTI (0) follow, one period each.
- FINISH lasts one system cycle, then the sequencer returns to IDLE.

Top module: `jtag_idcode_reader`

## Requirements
- R1: While reset is asserted and right after it, tck=0, tms=1, tdi=0, done=0, id_word=0 and vendor_match=0.
- R2: A transaction gives exactly 56 TCK rising edges. On the first five of them TMS=1. On the next five, TMS is 0,1,1,0,0 in that order.
- R3: On TCK rising edges 11 to 18, TDI carries 1,0,0,0,1,0,0,0, which is 0x11 sent LSB first. TMS is 0 on the first seven of these edges and 1 on the eighth. The target's instruction register then holds 0x11.
- R4: After the instruction, TMS is 1,1,0,0 on four edges. It is then 0 on 31 shift edges and 1 on the 32nd shift edge, with TDI=0 on all 32. The last two edges have TMS 1 then 0, which leaves the target in Run-Test-Idle.
- R5: TMS and TDI change only in a system cycle where TCK falls.
- R6: Every TCK high phase and every TCK low phase inside a transaction lasts TCK_HALF system cycles.
- R7: id_word holds the 32 TDO values sampled on the shift edges, with the first sample in bit 0.
- R8: done is high for exactly one system cycle, 112*TCK_HALF cycles after the clock edge that accepts start. id_word and vendor_match change on that same edge.
- R9: vendor_match is 1 exactly when id_word[11:0] equals MFR_ID (0x81B by default).
- R10: start is ignored while a transaction is running. It has no effect on the TCK sequence, the done timing or the number of done pulses.
- R11: Between transactions TCK is held low and TMS high.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| start | input | 1 | Begins one read when idle |
| tdo | input | 1 | Target data out |
| tck | output | 1 | Test clock to the target |
| tms | output | 1 | Test mode select |
| tdi | output | 1 | Target data in |
| done | output | 1 | One-cycle end strobe |
| id_word | output | 32 | Captured identification word |
| vendor_match | output | 1 | Manufacturer field equals MFR_ID |

## Verification
The bench places a behavioural target TAP, with an 8-bit instruction register, behind the block. It sweeps programmed identification words whose manufacturer fields match or differ from the configured value. With TCK_HALF=2, done, id_word and vendor_match are due 224 system cycles after the edge that accepts start. The bench counts edges from that point and samples every output on the falling system clock, so each registered change is seen one half period after it is made. It logs TMS and TDI on every TCK rise and compares them with the edge-by-edge script. It measures phase lengths and change timing continuously, and injects extra start pulses mid-run to confirm that the done timing does not move.

// File: rtl/jtag_rd_pkg.sv
package jtag_rd_pkg;
    typedef enum logic [3:0] {
        ST_IDLE,
        ST_TAP_RESET,
        ST_ENTER_RTI,
        ST_SEL_DR_A,
        ST_SEL_IR,
        ST_CAP_IR,
        ST_ENTER_SIR,
        ST_SHIFT_IR,
        ST_UPD_IR,
        ST_SEL_DR_B,
        ST_CAP_DR,
        ST_ENTER_SDR,
        ST_SHIFT_DR,
        ST_UPD_DR,
        ST_BACK_RTI,
        ST_FINISH
    } rd_state_e;
endpackage

// File: rtl/jtag_tck_gen.sv
module jtag_tck_gen #(
    parameter int TCK_HALF = 4
) (
    input  logic clk,
    input  logic rst_n,
    input  logic run,
    output logic tck,
    output logic rise_stb,
    output logic fall_stb
);
    localparam int HW = $clog2(TCK_HALF) + 1;
    localparam logic [HW-1:0] HALF_LAST = HW'(TCK_HALF - 1);

    logic [HW-1:0] phase_cnt;
    logic          phase_end;

    assign phase_end = run && (phase_cnt == HALF_LAST);
    assign rise_stb  = phase_end && !tck;
    assign fall_stb  = phase_end && tck;

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            phase_cnt <= '0;
            tck       <= 1'b0;
        end else if (!run) begin
            phase_cnt <= '0;
            tck       <= 1'b0;
        end else if (phase_end) begin
            phase_cnt <= '0;
            tck       <= !tck;
        end else begin
            phase_cnt <= phase_cnt + 1'b1;
        end
    end
endmodule

// File: rtl/jtag_rd_fsm.sv
module jtag_rd_fsm
    import jtag_rd_pkg::*;
#(
    parameter int              RESET_CYC = 5,
    parameter int              IR_W      = 8,
    parameter logic [IR_W-1:0] IR_CODE   = 8'h11,
    parameter int              ID_W      = 32
) (
    input  logic      clk,
    input  logic      rst_n,
    input  logic      start,
    input  logic      fall_stb,
    output rd_state_e state,
    output logic      tms,
    output logic      tdi,
    output logic      run,
    output logic      sample_en,
    output logic      finish_stb,
    output logic      done
);
    localparam int MAX_LEN = (ID_W > IR_W) ? ((ID_W > RESET_CYC) ? ID_W : RESET_CYC)
                                           : ((IR_W > RESET_CYC) ? IR_W : RESET_CYC);
    localparam int SW = $clog2(MAX_LEN) + 1;
    localparam logic [SW-1:0] RST_LAST = SW'(RESET_CYC - 1);
    localparam logic [SW-1:0] IR_LAST  = SW'(IR_W - 1);
    localparam logic [SW-1:0] ID_LAST  = SW'(ID_W - 1);

    rd_state_e     state_nx;
    logic [SW-1:0] step_cnt;
    logic [SW-1:0] step_last;
    logic          step_end;
    logic [IR_W-1:0] ir_bits;

    always_comb begin
        unique case (state)
            ST_TAP_RESET: step_last = RST_LAST;
            ST_SHIFT_IR:  step_last = IR_LAST;
            ST_SHIFT_DR:  step_last = ID_LAST;
            default:      step_last = '0;
        endcase
    end

    assign step_end = fall_stb && (step_cnt == step_last);

    always_comb begin
        state_nx = state;
        unique case (state)
            ST_IDLE:      if (start)    state_nx = ST_TAP_RESET;
            ST_TAP_RESET: if (step_end) state_nx = ST_ENTER_RTI;
            ST_ENTER_RTI: if (step_end) state_nx = ST_SEL_DR_A;
            ST_SEL_DR_A:  if (step_end) state_nx = ST_SEL_IR;
            ST_SEL_IR:    if (step_end) state_nx = ST_CAP_IR;
            ST_CAP_IR:    if (step_end) state_nx = ST_ENTER_SIR;
            ST_ENTER_SIR: if (step_end) state_nx = ST_SHIFT_IR;
            ST_SHIFT_IR:  if (step_end) state_nx = ST_UPD_IR;
            ST_UPD_IR:    if (step_end) state_nx = ST_SEL_DR_B;
            ST_SEL_DR_B:  if (step_end) state_nx = ST_CAP_DR;
            ST_CAP_DR:    if (step_end) state_nx = ST_ENTER_SDR;
            ST_ENTER_SDR: if (step_end) state_nx = ST_SHIFT_DR;
            ST_SHIFT_DR:  if (step_end) state_nx = ST_UPD_DR;
            ST_UPD_DR:    if (step_end) state_nx = ST_BACK_RTI;
            ST_BACK_RTI:  if (step_end) state_nx = ST_FINISH;
            ST_FINISH:                  state_nx = ST_IDLE;
            default:                    state_nx = ST_IDLE;
        endcase
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            state    <= ST_IDLE;
            step_cnt <= '0;
        end else begin
            state <= state_nx;
            if (state_nx != state) begin
                step_cnt <= '0;
            end else if (fall_stb) begin
                step_cnt <= step_cnt + 1'b1;
            end
        end
    end

    assign ir_bits = IR_CODE >> step_cnt;

    always_comb begin
        tms        = 1'b1;
        tdi        = 1'b0;
        run        = 1'b1;
        sample_en  = 1'b0;
        finish_stb = 1'b0;
        done       = 1'b0;
        unique case (state)
            ST_IDLE:      run = 1'b0;
            ST_TAP_RESET: tms = 1'b1;
            ST_ENTER_RTI: tms = 1'b0;
            ST_SEL_DR_A:  tms = 1'b1;
            ST_SEL_IR:    tms = 1'b1;
            ST_CAP_IR:    tms = 1'b0;
            ST_ENTER_SIR: tms = 1'b0;
            ST_SHIFT_IR: begin
                tms = (step_cnt == IR_LAST);
                tdi = ir_bits[0];
            end
            ST_UPD_IR:    tms = 1'b1;
            ST_SEL_DR_B:  tms = 1'b1;
            ST_CAP_DR:    tms = 1'b0;
            ST_ENTER_SDR: tms = 1'b0;
            ST_SHIFT_DR: begin
                tms       = (step_cnt == ID_LAST);
                sample_en = 1'b1;
            end
            ST_UPD_DR:    tms = 1'b1;
            ST_BACK_RTI: begin
                tms        = 1'b0;
                finish_stb = step_end;
            end
            ST_FINISH: begin
                run  = 1'b0;
                done = 1'b1;
            end
            default:      run = 1'b0;
        endcase
    end
endmodule

// File: rtl/jtag_id_capture.sv
module jtag_id_capture #(
    parameter int               ID_W   = 32,
    parameter int               MFR_W  = 12,
    parameter logic [MFR_W-1:0] MFR_ID = 12'h81B
) (
    input  logic            clk,
    input  logic            rst_n,
    input  logic            sample_stb,
    input  logic            tdo,
    input  logic            finish_stb,
    output logic [ID_W-1:0] id_word,
    output logic            vendor_match
);
    logic [ID_W-1:0] shreg;

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            shreg        <= '0;
            id_word      <= '0;
            vendor_match <= 1'b0;
        end else begin
            if (sample_stb) begin
                shreg <= {tdo, shreg[ID_W-1:1]};
            end
            if (finish_stb) begin
                id_word      <= shreg;
                vendor_match <= (shreg[MFR_W-1:0] == MFR_ID);
            end
        end
    end
endmodule

// File: rtl/jtag_idcode_reader.sv
module jtag_idcode_reader
    import jtag_rd_pkg::*;
#(
    parameter int               TCK_HALF  = 4,
    parameter int               RESET_CYC = 5,
    parameter int               IR_W      = 8,
    parameter logic [IR_W-1:0]  IR_CODE   = 8'h11,
    parameter int               ID_W      = 32,
    parameter int               MFR_W     = 12,
    parameter logic [MFR_W-1:0] MFR_ID    = 12'h81B
) (
    input  logic            clk,
    input  logic            rst_n,
    input  logic            start,
    input  logic            tdo,
    output logic            tck,
    output logic            tms,
    output logic            tdi,
    output logic            done,
    output logic [ID_W-1:0] id_word,
    output logic            vendor_match
);
    rd_state_e seq_state;
    logic      run;
    logic      rise_stb;
    logic      fall_stb;
    logic      sample_en;
    logic      finish_stb;

    jtag_tck_gen #(.TCK_HALF(TCK_HALF)) u_tck (
        .clk      (clk),
        .rst_n    (rst_n),
        .run      (run),
        .tck      (tck),
        .rise_stb (rise_stb),
        .fall_stb (fall_stb)
    );

    jtag_rd_fsm #(
        .RESET_CYC (RESET_CYC),
        .IR_W      (IR_W),
        .IR_CODE   (IR_CODE),
        .ID_W      (ID_W)
    ) u_fsm (
        .clk        (clk),
        .rst_n      (rst_n),
        .start      (start),
        .fall_stb   (fall_stb),
        .state      (seq_state),
        .tms        (tms),
        .tdi        (tdi),
        .run        (run),
        .sample_en  (sample_en),
        .finish_stb (finish_stb),
        .done       (done)
    );

    jtag_id_capture #(
        .ID_W   (ID_W),
        .MFR_W  (MFR_W),
        .MFR_ID (MFR_ID)
    ) u_cap (
        .clk          (clk),
        .rst_n        (rst_n),
        .sample_stb   (sample_en && rise_stb),
        .tdo          (tdo),
        .finish_stb   (finish_stb),
        .id_word      (id_word),
        .vendor_match (vendor_match)
    );
endmodule

// File: rtl/jtag_idcode_reader_chk.sv
module jtag_idcode_reader_chk
    import jtag_rd_pkg::*;
#(
    parameter int               TCK_HALF = 4,
    parameter int               ID_W     = 32,
    parameter int               MFR_W    = 12,
    parameter logic [MFR_W-1:0] MFR_ID   = 12'h81B
) (
    input logic            clk,
    input logic            rst_n,
    input logic            tck,
    input logic            tms,
    input logic            tdi,
    input logic            done,
    input logic [ID_W-1:0] id_word,
    input logic            vendor_match,
    input rd_state_e       seq_state
);
    localparam int HW = $clog2(TCK_HALF) + 2;
    localparam logic [HW-1:0] HALF_V = HW'(TCK_HALF);

    logic [HW-1:0] hi_len;

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n)   hi_len <= '0;
        else if (tck) hi_len <= hi_len + 1'b1;
        else          hi_len <= '0;
    end

    // R5
    tms_edge_chk: assert property (@(posedge clk) disable iff (!rst_n)
        !$stable(tms) |-> $fell(tck));

    // R5
    tdi_edge_chk: assert property (@(posedge clk) disable iff (!rst_n)
        !$stable(tdi) |-> $fell(tck));

    // R6
    tck_high_chk: assert property (@(posedge clk) disable iff (!rst_n)
        $fell(tck) |-> (hi_len == HALF_V));

    // R8
    done_pulse_chk: assert property (@(posedge clk) disable iff (!rst_n)
        done |=> !done);

    // R9
    vendor_flag_chk: assert property (@(posedge clk) disable iff (!rst_n)
        done |-> (vendor_match == (id_word[MFR_W-1:0] == MFR_ID)));

    // R4
    dr_tdi_low_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (seq_state == ST_SHIFT_DR) |-> !tdi);

    // R11
    idle_lines_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (seq_state == ST_IDLE) |-> (!tck && tms));

    // R10
    start_only_idle_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (seq_state == ST_TAP_RESET && $past(seq_state) != ST_TAP_RESET)
            |-> ($past(seq_state) == ST_IDLE));
endmodule

bind jtag_idcode_reader jtag_idcode_reader_chk #(
    .TCK_HALF (TCK_HALF),
    .ID_W     (ID_W),
    .MFR_W    (MFR_W),
    .MFR_ID   (MFR_ID)
) u_chk (
    .clk          (clk),
    .rst_n        (rst_n),
    .tck          (tck),
    .tms          (tms),
    .tdi          (tdi),
    .done         (done),
    .id_word      (id_word),
    .vendor_match (vendor_match),
    .seq_state    (seq_state)
);

// File: tb/jtag_idcode_reader_bench.sv
module jtag_idcode_reader_bench;
    localparam int H      = 2;
    localparam int STEPS  = 56;
    localparam int DONE_AT = 112 * H;

    typedef enum logic [3:0] {
        T_TLR, T_RTI, T_SDS, T_CDR, T_SDR, T_E1D, T_PDR, T_E2D, T_UDR,
        T_SIS, T_CIR, T_SIR, T_E1I, T_PIR, T_E2I, T_UIR
    } tap_e;

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        start = 1'b0;
    logic        tdo = 1'b0;
    logic        tck, tms, tdi, done, vendor_match;
    logic [31:0] id_word;

    int checks = 0;
    int fails  = 0;

    always #2 clk = !clk;

    jtag_idcode_reader #(.TCK_HALF(H)) u_jtag_idcode_reader (
        .clk          (clk),
        .rst_n        (rst_n),
        .start        (start),
        .tdo          (tdo),
        .tck          (tck),
        .tms          (tms),
        .tdi          (tdi),
        .done         (done),
        .id_word      (id_word),
        .vendor_match (vendor_match)
    );

    // behavioural target TAP
    tap_e        tap_st = T_PDR;
    logic [7:0]  ir = 8'hFF;
    logic [7:0]  ir_sh = 8'h00;
    logic [31:0] dr = 32'h0;
    logic [31:0] model_id = 32'h0;
    int          rise_total = 0;
    bit          tms_log [0:4095];
    bit          tdi_log [0:4095];

    function automatic tap_e tap_next(tap_e s, logic m);
        case (s)
            T_TLR: return m ? T_TLR : T_RTI;
            T_RTI: return m ? T_SDS : T_RTI;
            T_SDS: return m ? T_SIS : T_CDR;
            T_CDR: return m ? T_E1D : T_SDR;
            T_SDR: return m ? T_E1D : T_SDR;
            T_E1D: return m ? T_UDR : T_PDR;
            T_PDR: return m ? T_E2D : T_PDR;
            T_E2D: return m ? T_UDR : T_SDR;
            T_UDR: return m ? T_SDS : T_RTI;
            T_SIS: return m ? T_TLR : T_CIR;
            T_CIR: return m ? T_E1I : T_SIR;
            T_SIR: return m ? T_E1I : T_SIR;
            T_E1I: return m ? T_UIR : T_PIR;
            T_PIR: return m ? T_E2I : T_PIR;
            T_E2I: return m ? T_UIR : T_SIR;
            default: return m ? T_SDS : T_RTI;
        endcase
    endfunction

    always @(posedge tck) begin
        if (rise_total < 4096) begin
            tms_log[rise_total] = tms;
            tdi_log[rise_total] = tdi;
        end
        rise_total = rise_total + 1;
        case (tap_st)
            T_TLR: ir <= 8'hFF;
            T_CIR: ir_sh <= 8'h01;
            T_SIR: ir_sh <= {tdi, ir_sh[7:1]};
            T_UIR: ir <= ir_sh;
            T_CDR: dr <= (ir == 8'h11) ? model_id : 32'h0;
            T_SDR: dr <= (ir == 8'h11) ? {tdi, dr[31:1]} : {31'h0, tdi};
            default: ;
        endcase
        tap_st <= tap_next(tap_st, tms);
    end

    always @(negedge tck) begin
        tdo <= (tap_st == T_SDR) ? dr[0] : ((tap_st == T_SIR) ? ir_sh[0] : 1'b0);
    end

    // line monitors on the falling system clock
    logic p_tck = 1'b0, p_tms = 1'b1, p_tdi = 1'b0;
    int   edge_viol = 0, good_hi = 0, bad_hi = 0, good_lo = 0, ph_len = 0;

    always @(negedge clk) begin
        if (rst_n) begin
            if ((tms != p_tms || tdi != p_tdi) && !(p_tck && !tck)) edge_viol++;
            if (tck != p_tck) begin
                if (p_tck) begin
                    if (ph_len == H) good_hi++; else bad_hi++;
                end else if (ph_len == H) begin
                    good_lo++;
                end
                ph_len = 1;
            end else begin
                ph_len++;
            end
        end
        p_tck = tck; p_tms = tms; p_tdi = tdi;
    end

    task automatic chk(bit ok, string req, string what, logic [31:0] act, logic [31:0] exp);
        checks++;
        if (!ok) begin
            fails++;
            $display("FAIL %s %s actual=%h expected=%h", req, what, act, exp);
        end
    endtask

    function automatic bit exp_tms(int k);
        if (k < 5)  return 1'b1;
        if (k == 5) return 1'b0;
        if (k < 8)  return 1'b1;
        if (k < 10) return 1'b0;
        if (k < 18) return k == 17;
        if (k < 20) return 1'b1;
        if (k < 22) return 1'b0;
        if (k < 54) return k == 53;
        if (k == 54) return 1'b1;
        return 1'b0;
    endfunction

    function automatic bit exp_tdi(int k);
        if (k >= 10 && k < 18) return 1'((8'h11 >> (k - 10)) & 8'h01);
        return 1'b0;
    endfunction

    task automatic run_one(logic [31:0] id, bit extra);
        int base, v0, gh0, bh0, gl0, dones, done_cyc, err_a, err_b, err_c;
        logic [31:0] got_word;
        logic        got_match, want_match;
        model_id = id;
        base = rise_total; v0 = edge_viol; gh0 = good_hi; bh0 = bad_hi; gl0 = good_lo;
        dones = 0; done_cyc = -1; got_word = 32'h0; got_match = 1'b0;
        @(negedge clk) start = 1'b1;
        @(negedge clk) start = 1'b0;
        for (int cyc = 1; cyc <= DONE_AT + 20; cyc++) begin
            start = extra && (cyc == 3 || cyc == 97 || cyc == DONE_AT - 1);
            @(negedge clk);
            if (done) begin
                dones++;
                done_cyc = cyc;
                got_word = id_word;
                got_match = vendor_match;
            end
        end
        start = 1'b0;
        want_match = (id[11:0] == 12'h81B);
        err_a = 0; err_b = 0; err_c = 0;
        for (int k = 0; k < STEPS; k++) begin
            bit bad;
            bad = (tms_log[base + k] != exp_tms(k)) || (tdi_log[base + k] != exp_tdi(k));
            if (bad && k < 10) err_a++;
            else if (bad && k < 18) err_b++;
            else if (bad) err_c++;
        end
        chk(rise_total - base == STEPS, "R2", "tck rise count", 32'(rise_total - base), 32'(STEPS));
        chk(err_a == 0, "R2", "reset and IR-path edges wrong", 32'(err_a), 0);
        chk(err_b == 0, "R3", "instruction edges wrong", 32'(err_b), 0);
        chk(ir == 8'h11, "R3", "target instruction", 32'(ir), 32'h11);
        chk(err_c == 0, "R4", "data path edges wrong", 32'(err_c), 0);
        chk(tap_st == T_RTI, "R4", "target end state", 32'(tap_st), 32'(T_RTI));
        chk(edge_viol == v0, "R5", "line change off tck fall", 32'(edge_viol - v0), 0);
        chk(good_hi - gh0 == STEPS && bad_hi == bh0, "R6", "high phases of H", 32'(good_hi - gh0), 32'(STEPS));
        chk(good_lo - gl0 == STEPS - 1, "R6", "inner low phases of H", 32'(good_lo - gl0), 32'(STEPS - 1));
        chk(got_word == id, "R7", "captured word", got_word, id);
        chk(done_cyc == DONE_AT, extra ? "R10" : "R8", "done cycle", 32'(done_cyc), 32'(DONE_AT));
        chk(dones == 1, extra ? "R10" : "R8", "done pulses", 32'(dones), 1);
        chk(got_match == want_match, "R9", "vendor flag", 32'(got_match), 32'(want_match));
        chk(!tck && tms, "R11", "idle tck/tms", {30'h0, tck, tms}, 32'h1);
    endtask

    initial begin
        repeat (3) @(negedge clk);
        chk(!tck && tms && !tdi && !done && id_word == 0 && !vendor_match, "R1", "lines in reset",
            {26'h0, tck, tms, tdi, done, vendor_match, |id_word}, 32'h10);
        rst_n = 1'b1;
        repeat (3) @(negedge clk);
        chk(!tck && tms && !tdi && !done && id_word == 0 && !vendor_match, "R1", "lines after reset",
            {26'h0, tck, tms, tdi, done, vendor_match, |id_word}, 32'h10);
        run_one(32'h0900281B, 1'b0);
        run_one(32'h1100381B, 1'b1);
        run_one(32'h0000081B, 1'b0);
        run_one(32'hFFFFFFFF, 1'b0);
        run_one(32'h00000000, 1'b1);
        for (int i = 0; i < 12; i++) begin
            logic [31:0] mix;
            logic [11:0] mfr;
            mix = 32'h9E3779B9 * (i + 1);
            mfr = (i % 2 == 0) ? 12'h81B : (12'h81B ^ (12'h001 << (i % 12)));
            run_one({mix[31:12], mfr}, i % 3 == 0);
        end
        $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
        $finish;
    end

    initial begin
        repeat (150000) @(posedge clk);
        checks++;
        fails++;
        $display("FAIL watchdog run did not end actual=%0d expected=%0d", 150000, 0);
        $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
        $finish;
    end
endmodule